// File: doc/BRIEF.md
# Text-Mode Character Display Renderer

This block turns a character buffer into a stream of RGB pixels for an 80-column by 25-row text screen. Every cell is an 8x8 pixel box, so the visible picture is 640 by 200 pixels. A free-running horizontal and vertical counter walks a raster that may be larger than the visible picture. For each visible coordinate the block reads a 32-bit buffer word that packs two neighbouring cells and picks the cell that covers the pixel. It then reads the glyph byte for that cell's character and pixel row from a font store. The glyph bit, together with the cell's attribute byte, chooses one of sixteen fixed palette colours.

Both memories sit outside the block and have a one-cycle registered read: an address presented in one cycle returns its data in the next. The block drives the addresses and takes the returned data. One pixel leaves per clock with a valid strobe and markers for the end of a line and the end of a frame. A pipeline aligns each pixel's attribute and bit position with its glyph byte, so the pixel for a coordinate appears three cycles after the counter holds that coordinate.

Top module: `txtdisp_render`

## Requirements
- R1: While rst is high, and in the cycle after any clock edge that sampled rst high, pix_valid, line_end and frame_end are 0 and pix_rgb is 24'h000000.
- R2: After rst falls, the pixel for (x=0, y=0) is the first valid pixel. pix_valid first reads 1 after exactly three rising edges with rst low, and valid pixels then follow on consecutive clocks across the line.
- R3: Each frame holds exactly 200 lines of exactly 640 valid pixels in raster order, which is 128000 valid pixels between frame_end pulses.
- R4: Each buffer word holds two cells. Pixel columns with x bit 3 equal to 0 use the left cell: code in bits 7:0, attribute in bits 15:8. Pixel columns with x bit 3 equal to 1 use the right cell: code in bits 23:16, attribute in bits 31:24.
- R5: The buffer word index for pixel (x, y) is (y/8)*40 + x/16, so the top-left cell pair sits in word 0 and the index rises by one for every two columns.
- R6: The font address is code*8 + (y mod 8). Pixel column k (k = x mod 8) within the cell takes glyph bit 7-k, so the leftmost pixel of the cell is the glyph byte's most significant bit.
- R7: A set glyph bit selects palette index attribute[3:0]. A clear bit selects palette index {0, attribute[6:4]}. Attribute bit 7 has no effect on the pixel.
- R8: Palette indices 0 to 15 give RGB (red in bits 23:16) 000000, 0000AA, 00AA00, 00AAAA, AA0000, AA00AA, AA5500, AAAAAA, 555555, 5555FF, 55FF55, 55FFFF, FF5555, FF55FF, FFFF55, FFFFFF.
- R9: line_end is high together with the valid pixel at x=639 of every visible row and at no other time. frame_end is high only together with the pixel (639, 199), in the same cycle as that row's line_end.
- R10: Whenever pix_valid is 0, pix_rgb is 24'h000000 and both markers are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| cell_addr | output | 10 | Buffer word address (width $clog2(COLS*ROWS/2)) |
| cell_word | input | 32 | Buffer word, returned one cycle after cell_addr |
| glyph_addr | output | 11 | Font byte address: code and glyph row |
| glyph_row | input | 8 | Glyph byte, returned one cycle after glyph_addr |
| pix_valid | output | 1 | Pixel strobe, high for visible pixels |
| pix_rgb | output | 24 | Pixel colour, red in 23:16, green in 15:8, blue in 7:0 |
| line_end | output | 1 | Marks the last pixel of a visible row |
| frame_end | output | 1 | Marks the last pixel of the frame |

## Verification
At the bottom-right pixel, the end-of-line marker and the end-of-frame marker fire in the same cycle. That same pixel is also the last cell of the buffer in its right half. The bench places a known word at buffer index 999 and runs a full frame. At (639,199) it checks the colour against its own model of the cell and glyph. It also requires that both markers are high there, that frame_end appears nowhere else, and that line_end appears on exactly the 200 row-final pixels.

// File: rtl/txtdisp_pkg.sv
package txtdisp_pkg;

    localparam int GLYPH_PX  = 8;
    localparam int CODE_W    = 8;
    localparam int ATTR_W    = 8;
    localparam int WORD_W    = 32;
    localparam int CELLS_PER = 2;
    localparam int CELL_BITS = WORD_W / CELLS_PER;
    localparam int FONT_AW   = CODE_W + $clog2(GLYPH_PX);
    localparam int RGB_W     = 24;

    typedef logic [RGB_W-1:0] rgb_t;
    typedef logic [3:0]       pal_idx_t;

    // Stage after the buffer address is issued
    typedef struct packed {
        logic       vis;
        logic       eol;
        logic       eof;
        logic       half;
        logic [2:0] row;
        logic [2:0] col;
    } fetch_st_t;

    // Stage after the font address is issued
    typedef struct packed {
        logic              vis;
        logic              eol;
        logic              eof;
        logic [2:0]        col;
        logic [ATTR_W-1:0] attr;
    } glyph_st_t;

    // Fixed 16-colour palette built from the index bits
    function automatic rgb_t pal_lookup(input pal_idx_t idx);
        logic [7:0] lo, hi, r, g, b;
        lo = idx[3] ? 8'h55 : 8'h00;
        hi = idx[3] ? 8'hFF : 8'hAA;
        r  = idx[2] ? hi : lo;
        g  = idx[1] ? hi : lo;
        b  = idx[0] ? hi : lo;
        if (idx == 4'd6) g = 8'h55;
        return {r, g, b};
    endfunction

    function automatic logic is_palette_color(input rgb_t c);
        logic hit;
        hit = 1'b0;
        for (int i = 0; i < 16; i++) begin
            if (pal_lookup(pal_idx_t'(i)) == c) hit = 1'b1;
        end
        return hit;
    endfunction

endpackage

// File: rtl/txtdisp_scan.sv
module txtdisp_scan #(
    parameter int H_TOTAL = 800,
    parameter int V_TOTAL = 262,
    parameter int VIS_W   = 640,
    parameter int VIS_H   = 200,
    localparam int XW     = $clog2(H_TOTAL),
    localparam int YW     = $clog2(V_TOTAL)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [XW-1:0] x,
    output logic [YW-1:0] y,
    output logic          vis,
    output logic          last_col,
    output logic          last_row
);

    logic x_wrap;
    logic y_wrap;

    assign x_wrap = (x == XW'(H_TOTAL - 1));
    assign y_wrap = (y == YW'(V_TOTAL - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            x <= '0;
            y <= '0;
        end else begin
            if (x_wrap) begin
                x <= '0;
                y <= y_wrap ? '0 : y + 1'b1;
            end else begin
                x <= x + 1'b1;
            end
        end
    end

    assign vis      = (x < XW'(VIS_W)) && (y < YW'(VIS_H));
    assign last_col = (x == XW'(VIS_W - 1));
    assign last_row = (y == YW'(VIS_H - 1));

endmodule

// File: rtl/txtdisp_fetch.sv
module txtdisp_fetch
    import txtdisp_pkg::*;
#(
    parameter int COLS   = 80,
    parameter int XW     = 10,
    parameter int YW     = 9,
    parameter int BUF_AW = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [XW-1:0]     x,
    input  logic [YW-1:0]     y,
    input  logic              vis,
    input  logic              last_col,
    input  logic              last_row,
    output logic [BUF_AW-1:0] cell_addr,
    output fetch_st_t         st
);

    localparam int WORDS_PER_ROW = COLS / CELLS_PER;
    localparam int ROW_SHIFT     = $clog2(GLYPH_PX);
    localparam int PAIR_SHIFT    = $clog2(GLYPH_PX * CELLS_PER);

    logic [BUF_AW-1:0] text_row;
    logic [BUF_AW-1:0] pair_col;

    assign text_row  = BUF_AW'(y >> ROW_SHIFT);
    assign pair_col  = BUF_AW'(x >> PAIR_SHIFT);
    assign cell_addr = BUF_AW'(text_row * BUF_AW'(WORDS_PER_ROW)) + pair_col;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            st.vis  <= vis;
            st.eol  <= vis && last_col;
            st.eof  <= vis && last_col && last_row;
            st.half <= x[ROW_SHIFT];
            st.row  <= y[2:0];
            st.col  <= x[2:0];
        end
    end

endmodule

// File: rtl/txtdisp_glyph.sv
module txtdisp_glyph
    import txtdisp_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  fetch_st_t          st_in,
    input  logic [WORD_W-1:0]  cell_word,
    output logic [FONT_AW-1:0] glyph_addr,
    output glyph_st_t          st_out
);

    logic [CODE_W-1:0] codes [CELLS_PER];
    logic [ATTR_W-1:0] attrs [CELLS_PER];
    logic [CODE_W-1:0] code_sel;
    logic [ATTR_W-1:0] attr_sel;

    // Unpack every cell of the word; cell c occupies bits [c*16 +: 16]
    for (genvar c = 0; c < CELLS_PER; c++) begin : g_unpack
        assign codes[c] = cell_word[c*CELL_BITS +: CODE_W];
        assign attrs[c] = cell_word[c*CELL_BITS + CODE_W +: ATTR_W];
    end

    assign code_sel   = codes[st_in.half];
    assign attr_sel   = attrs[st_in.half];
    assign glyph_addr = {code_sel, st_in.row};

    always_ff @(posedge clk) begin
        if (rst) begin
            st_out <= '0;
        end else begin
            st_out.vis  <= st_in.vis;
            st_out.eol  <= st_in.eol;
            st_out.eof  <= st_in.eof;
            st_out.col  <= st_in.col;
            st_out.attr <= attr_sel;
        end
    end

endmodule

// File: rtl/txtdisp_color.sv
module txtdisp_color
    import txtdisp_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  glyph_st_t           st_in,
    input  logic [GLYPH_PX-1:0] glyph_row,
    output logic                pix_valid,
    output logic                line_end,
    output logic                frame_end,
    output rgb_t                pix_rgb
);

    logic     fg_on;
    pal_idx_t idx;

    // Leftmost pixel of the cell is the glyph's most significant bit
    assign fg_on = glyph_row[3'd7 - st_in.col];
    assign idx   = fg_on ? st_in.attr[3:0] : {1'b0, st_in.attr[6:4]};

    always_ff @(posedge clk) begin
        if (rst) begin
            pix_valid <= 1'b0;
            line_end  <= 1'b0;
            frame_end <= 1'b0;
            pix_rgb   <= '0;
        end else begin
            pix_valid <= st_in.vis;
            line_end  <= st_in.eol;
            frame_end <= st_in.eof;
            pix_rgb   <= st_in.vis ? pal_lookup(idx) : '0;
        end
    end

endmodule

// File: rtl/txtdisp_render.sv
module txtdisp_render
    import txtdisp_pkg::*;
#(
    parameter int COLS    = 80,
    parameter int ROWS    = 25,
    parameter int H_TOTAL = 800,
    parameter int V_TOTAL = 262,
    localparam int BUF_AW = $clog2(COLS * ROWS / CELLS_PER)
) (
    input  logic               clk,
    input  logic               rst,
    output logic [BUF_AW-1:0]  cell_addr,
    input  logic [31:0]        cell_word,
    output logic [10:0]        glyph_addr,
    input  logic [7:0]         glyph_row,
    output logic               pix_valid,
    output logic [23:0]        pix_rgb,
    output logic               line_end,
    output logic               frame_end
);

    localparam int VIS_W = COLS * GLYPH_PX;
    localparam int VIS_H = ROWS * GLYPH_PX;
    localparam int XW    = $clog2(H_TOTAL);
    localparam int YW    = $clog2(V_TOTAL);

    logic [XW-1:0] x;
    logic [YW-1:0] y;
    logic          vis, last_col, last_row;
    fetch_st_t     st_fetch;
    glyph_st_t     st_glyph;

    txtdisp_scan #(
        .H_TOTAL (H_TOTAL),
        .V_TOTAL (V_TOTAL),
        .VIS_W   (VIS_W),
        .VIS_H   (VIS_H)
    ) scan_i (
        .clk      (clk),
        .rst      (rst),
        .x        (x),
        .y        (y),
        .vis      (vis),
        .last_col (last_col),
        .last_row (last_row)
    );

    txtdisp_fetch #(
        .COLS   (COLS),
        .XW     (XW),
        .YW     (YW),
        .BUF_AW (BUF_AW)
    ) fetch_i (
        .clk       (clk),
        .rst       (rst),
        .x         (x),
        .y         (y),
        .vis       (vis),
        .last_col  (last_col),
        .last_row  (last_row),
        .cell_addr (cell_addr),
        .st        (st_fetch)
    );

    txtdisp_glyph glyph_i (
        .clk        (clk),
        .rst        (rst),
        .st_in      (st_fetch),
        .cell_word  (cell_word),
        .glyph_addr (glyph_addr),
        .st_out     (st_glyph)
    );

    txtdisp_color color_i (
        .clk       (clk),
        .rst       (rst),
        .st_in     (st_glyph),
        .glyph_row (glyph_row),
        .pix_valid (pix_valid),
        .line_end  (line_end),
        .frame_end (frame_end),
        .pix_rgb   (pix_rgb)
    );

endmodule

// File: rtl/txtdisp_render_chk.sv
module txtdisp_render_chk
    import txtdisp_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        pix_valid,
    input logic        line_end,
    input logic        frame_end,
    input logic [23:0] pix_rgb
);

    logic [1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst)                   since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 1'b1;
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        $past(rst) |-> (!pix_valid && !line_end && !frame_end && pix_rgb == '0)); // R1

    AST_PIPE_LATENCY: assert property (@(posedge clk) disable iff (rst)
        pix_valid |-> (since_rst == 2'd3)); // R2

    AST_PALETTE_ONLY: assert property (@(posedge clk) disable iff (rst)
        pix_valid |-> is_palette_color(pix_rgb)); // R8

    AST_FRAME_ON_LINE: assert property (@(posedge clk) disable iff (rst)
        frame_end |-> (line_end && pix_valid)); // R9

    AST_LINE_PULSE: assert property (@(posedge clk) disable iff (rst)
        line_end |=> !line_end); // R9

    AST_BLANK_BLACK: assert property (@(posedge clk) disable iff (rst)
        !pix_valid |-> (pix_rgb == '0 && !line_end && !frame_end)); // R10

endmodule

bind txtdisp_render txtdisp_render_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .pix_valid (pix_valid),
    .line_end  (line_end),
    .frame_end (frame_end),
    .pix_rgb   (pix_rgb)
);

// File: tb/txtdisp_render_tb_top.sv
module txtdisp_render_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [9:0]  cell_addr;
    logic [31:0] cell_word;
    logic [10:0] glyph_addr;
    logic [7:0]  glyph_row;
    logic        pix_valid;
    logic [23:0] pix_rgb;
    logic        line_end;
    logic        frame_end;

    always #10 clk = ~clk;

    txtdisp_render #(
        .COLS    (80),
        .ROWS    (25),
        .H_TOTAL (656),
        .V_TOTAL (204)
    ) dut_i (
        .clk        (clk),
        .rst        (rst),
        .cell_addr  (cell_addr),
        .cell_word  (cell_word),
        .glyph_addr (glyph_addr),
        .glyph_row  (glyph_row),
        .pix_valid  (pix_valid),
        .pix_rgb    (pix_rgb),
        .line_end   (line_end),
        .frame_end  (frame_end)
    );

    // Memory models with one-cycle registered read
    logic [31:0] bufm  [0:1023];
    logic [7:0]  fontm [0:2047];

    always @(posedge clk) begin
        cell_word <= bufm[cell_addr];
        glyph_row <= fontm[glyph_addr];
    end

    int n_tests = 0;
    int n_fail  = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] ref_pal(input logic [3:0] i);
        case (i)
            4'd0:  return 24'h000000;
            4'd1:  return 24'h0000AA;
            4'd2:  return 24'h00AA00;
            4'd3:  return 24'h00AAAA;
            4'd4:  return 24'hAA0000;
            4'd5:  return 24'hAA00AA;
            4'd6:  return 24'hAA5500;
            4'd7:  return 24'hAAAAAA;
            4'd8:  return 24'h555555;
            4'd9:  return 24'h5555FF;
            4'd10: return 24'h55FF55;
            4'd11: return 24'h55FFFF;
            4'd12: return 24'hFF5555;
            4'd13: return 24'hFF55FF;
            4'd14: return 24'hFFFF55;
            default: return 24'hFFFFFF;
        endcase
    endfunction

    // Reference pixel from R4..R8
    function automatic logic [23:0] ref_pixel(input int px, input int py);
        logic [31:0] w;
        logic [7:0]  code, attr, g;
        logic        b;
        w    = bufm[(py / 8) * 40 + px / 16];
        code = ((px / 8) % 2 == 1) ? w[23:16] : w[7:0];
        attr = ((px / 8) % 2 == 1) ? w[31:24] : w[15:8];
        g    = fontm[code * 8 + py % 8];
        b    = g[7 - (px % 8)];
        return b ? ref_pal(attr[3:0]) : ref_pal({1'b0, attr[6:4]});
    endfunction

    typedef struct packed {
        logic [9:0]  x;
        logic [7:0]  y;
        logic [23:0] rgb;
    } probe_t;

    localparam int NPROBE = 15;
    localparam probe_t PROBES [NPROBE] = '{
        '{10'd0,   8'd0,   24'hFFFF55},  // R4 R7 left cell, fg
        '{10'd4,   8'd0,   24'h0000AA},  // R6 R7 left cell, bg
        '{10'd0,   8'd1,   24'h0000AA},  // R6 glyph row 1
        '{10'd7,   8'd1,   24'hFFFF55},  // R6 bit 0 column 7
        '{10'd8,   8'd0,   24'h00AA00},  // R4 R7 right cell bg, attr bit7 set
        '{10'd15,  8'd0,   24'hAA00AA},  // R4 right cell fg
        '{10'd16,  8'd0,   24'hFF55FF},  // R5 second word left
        '{10'd24,  8'd0,   24'h55FFFF},  // R5 second word right
        '{10'd0,   8'd8,   24'hAAAAAA},  // R7 attr F0, bit7 ignored
        '{10'd8,   8'd8,   24'hAAAAAA},  // R7 attr 70
        '{10'd16,  8'd8,   24'h555555},  // R5 word 41
        '{10'd632, 8'd198, 24'hFF5555},  // R8 last word fg
        '{10'd633, 8'd198, 24'hAA0000},  // R8 last word bg
        '{10'd639, 8'd199, 24'hAA0000},  // R9 bottom-right pixel
        '{10'd624, 8'd199, 24'h000000}   // R8 palette 0
    };

    logic [23:0] probe_got [NPROBE];

    bit mon_en     = 1'b0;
    bit frame_done = 1'b0;
    int bx = 0, by = 0;
    int nvalid = 0, nlines = 0, nframe_end = 0;
    int mism_pix = 0, mism_mark = 0, mism_blank = 0;

    always @(negedge clk) begin
        if (mon_en && !rst && !frame_done) begin
            if (pix_valid) begin
                nvalid++;
                if (pix_rgb !== ref_pixel(bx, by)) mism_pix++;
                if (line_end !== (bx == 639)) mism_mark++;
                if (frame_end !== (bx == 639 && by == 199)) mism_mark++;
                for (int i = 0; i < NPROBE; i++)
                    if (bx == int'(PROBES[i].x) && by == int'(PROBES[i].y))
                        probe_got[i] = pix_rgb;
                if (frame_end) begin
                    nframe_end++;
                    frame_done = 1'b1;
                end
                if (line_end) begin
                    nlines++;
                    bx = 0;
                    by++;
                end else begin
                    bx++;
                end
            end else if (pix_rgb !== 24'h0 || line_end || frame_end) begin
                mism_blank++;
            end
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int lat;
        for (int i = 0; i < 1024; i++) bufm[i] = i * 32'h9E3779B1 + 32'h12345678;
        for (int a = 0; a < 2048; a++) begin
            logic [10:0] av;
            av = 11'(a);
            fontm[a] = av[0] ? ~av[10:3] : av[10:3];
        end
        bufm[0]   = 32'hA50F1EF0;
        bufm[1]   = 32'h0BFF0DFF;
        bufm[40]  = 32'h7000F000;
        bufm[41]  = 32'h000008FF;
        bufm[999] = 32'h4C810000;
        for (int i = 0; i < NPROBE; i++) probe_got[i] = 24'hDEAD00;

        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(!pix_valid && !line_end && !frame_end && pix_rgb == 24'h0,
            "R1 reset state", {pix_valid, line_end, frame_end, 5'd0, pix_rgb}, 32'h0);

        rst    = 1'b0;
        mon_en = 1'b1;
        lat    = 0;
        do begin
            @(posedge clk);
            lat++;
            @(negedge clk);
        end while (!pix_valid && lat < 10);
        chk(lat == 3, "R2 first pixel latency", lat, 3);

        while (!frame_done) @(negedge clk);

        for (int i = 0; i < NPROBE; i++)
            chk(probe_got[i] === PROBES[i].rgb, $sformatf("R4-R9 probe %0d", i),
                {8'd0, probe_got[i]}, {8'd0, PROBES[i].rgb});

        chk(nvalid == 128000, "R3 valid pixels per frame", nvalid, 128000);
        chk(nlines == 200,    "R3 lines per frame", nlines, 200);
        chk(mism_pix == 0,    "R6 full-frame pixel compare", mism_pix, 0);
        chk(mism_mark == 0,   "R9 marker placement", mism_mark, 0);
        chk(nframe_end == 1,  "R9 frame_end count", nframe_end, 1);
        chk(mism_blank == 0,  "R10 idle output", mism_blank, 0);

        // Reset in the middle of a visible line
        while (!pix_valid) @(negedge clk);
        repeat (37) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(!pix_valid && !line_end && !frame_end && pix_rgb == 24'h0,
            "R1 reset mid-line", {pix_valid, line_end, frame_end, 5'd0, pix_rgb}, 32'h0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule